// File: doc/BRIEF.md
# I2C Master Byte Sequencer

This block sits between a host-side command register and a bit-level I2C engine. Each host request carries a set of command flags (generate a start condition, transmit a byte, receive a byte, generate a stop condition) together with an acknowledge value and a transmit byte. The block turns that request into an ordered series of single-bit commands: an optional start, eight data bits, one acknowledge bit and an optional stop. It issues each one only after the previous one has completed.

For a transmit, the host byte is captured in a transmit register and copied into a shift register, then sent most significant bit first. On the ninth bit the block samples the slave's acknowledge. For a receive, eight bit-read commands shift the line value into the shift register. The finished byte is copied into a receive register, and the host-supplied acknowledge value is then driven on the ninth bit. An address phase is an ordinary transmit whose byte holds the 7-bit slave address in bits 7..1 and the direction in bit 0. Any number of data requests may follow before a stop.

Top module: `i2c_byte_seq`

## Requirements
- R1: After reset, busy, done and bitGo are 0, rxByte is 0x00 and rxAck is 1.
- R2: A request (cmdValid high for one cycle) is taken only while busy is 0. It makes busy 1 from the next cycle on. Requests that arrive while busy is 1 change neither the bit commands nor the transmitted data.
- R3: At most one bit command is outstanding: bitGo is never raised again until bitDone has answered the previous one.
- R4: Bit commands are issued in this order: start (if requested), the eight data bits, the acknowledge bit, then stop (if requested). Only the requested pieces are issued.
- R5: On a transmit, the data bits are bit-write commands carrying txByte as captured at the request, most significant bit first.
- R6: On a transmit, the acknowledge bit is a bit-read command, and the value returned on bitRxd is stored in rxAck (0 = acknowledged). rxByte is left unchanged.
- R7: On a receive, eight bit-read commands are issued. The returned bits, first one as the most significant, appear in rxByte by the time done is raised. rxAck is left unchanged.
- R8: On a receive, the acknowledge bit is a bit-write command whose bitTxd equals the ackValue captured at the request.
- R9: done is high for exactly one cycle. It is raised in the cycle after the edge at which the final bitDone is sampled, and busy drops in the cycle after done.
- R10: When both cmdWrite and cmdRead are set, the request is handled as a transmit.
- R11: A request with no command flag set raises done in the cycle after it is taken and issues no bit command.
- R12: bitCmd encodings while bitGo is high are: 1 start, 2 stop, 3 bit-write, 4 bit-read. bitTxd is 1 during the receive data bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdValid | input | 1 | One-cycle request strobe |
| cmdStart | input | 1 | Issue a start condition first |
| cmdStop | input | 1 | Issue a stop condition last |
| cmdRead | input | 1 | Receive one byte |
| cmdWrite | input | 1 | Transmit one byte |
| ackValue | input | 1 | Acknowledge level driven after a received byte |
| txByte | input | 8 | Byte to transmit (address byte: address in 7..1, direction in 0) |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| rxAck | output | 1 | Last acknowledge sampled on a transmit, 0 = acknowledged |
| rxByte | output | 8 | Last received byte |
| bitGo | output | 1 | One-cycle strobe issuing a bit command |
| bitCmd | output | 3 | Bit command code, valid with bitGo |
| bitTxd | output | 1 | Line value for a bit-write command |
| bitDone | input | 1 | Bit engine completion strobe |
| bitRxd | input | 1 | Line value sampled by the bit engine, valid with bitDone |

## Verification
The bench's bit-engine model answers each command a fixed latency after bitGo, so every bit costs a known number of cycles. done is due exactly that many cycles, times the number of expected bit commands, after the accepting edge. The bench counts falling edges from the accepting edge and requires done at exactly that count, which confirms R9 and R11. The receive and acknowledge registers are read on the falling edge after done, when the copy into them has already been made. The logged command stream is compared after each request against a list built from the request flags.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;

  // Bit-level engine command codes (fixed, decoded by the bit engine)
  typedef enum logic [2:0] {
    BIT_NOP   = 3'd0,
    BIT_START = 3'd1,
    BIT_STOP  = 3'd2,
    BIT_WRITE = 3'd3,
    BIT_READ  = 3'd4
  } bitOp_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_ACK,
    ST_STOP,
    ST_DONE
  } seqState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadTx;     // capture host byte into transmit register
    logic enterData;  // load shift register, clear bit counter
    logic fromHost;   // with enterData: take the host byte directly
    logic shiftBit;   // one data bit completed
    logic copyRx;     // shift register -> receive register
    logic storeAck;   // sampled acknowledge -> rxAck
  } dpStrobe_t;

endpackage

// File: rtl/i2cseq_datapath.sv
module i2cseq_datapath
  import i2cseq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] txByte,
  input  logic              bitRxd,
  output logic              shiftMsb,
  output logic              lastBit,
  output logic              rxAck,
  output logic [DATA_W-1:0] rxByte
);

  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] txReg;
  logic [DATA_W-1:0] shiftReg;
  logic [CNT_W-1:0]  bitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txReg <= '0;
    end else if (strobe.loadTx) begin
      txReg <= txByte;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
    end else if (strobe.enterData) begin
      shiftReg <= strobe.fromHost ? txByte : txReg;
      bitCnt   <= '0;
    end else if (strobe.shiftBit) begin
      shiftReg <= {shiftReg[DATA_W-2:0], bitRxd};
      bitCnt   <= bitCnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte <= '0;
      rxAck  <= 1'b1;
    end else begin
      if (strobe.copyRx)   rxByte <= shiftReg;
      if (strobe.storeAck) rxAck  <= bitRxd;
    end
  end

  assign shiftMsb = shiftReg[DATA_W-1];
  assign lastBit  = (bitCnt == LAST_IDX);

endmodule

// File: rtl/i2cseq_ctrl.sv
module i2cseq_ctrl
  import i2cseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic       cmdStart,
  input  logic       cmdStop,
  input  logic       cmdRead,
  input  logic       cmdWrite,
  input  logic       ackValue,
  input  logic       shiftMsb,
  input  logic       lastBit,
  input  logic       bitDone,
  output dpStrobe_t  strobe,
  output logic       bitGo,
  output logic [2:0] bitCmd,
  output logic       bitTxd,
  output logic       busy,
  output logic       done
);

  seqState_e state, stateNext;
  logic pending;
  logic doStop, doRead, doWrite, ackVal;
  logic isBitState, finish, writeMode, readMode, wantData;

  assign writeMode  = doWrite;
  assign readMode   = doRead & ~doWrite;
  assign wantData   = doWrite | doRead;
  assign isBitState = (state == ST_START) || (state == ST_DATA) ||
                      (state == ST_ACK)   || (state == ST_STOP);
  assign bitGo      = isBitState & ~pending;
  assign finish     = isBitState & pending & bitDone;
  assign busy       = (state != ST_IDLE);
  assign done       = (state == ST_DONE);

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (cmdValid) begin
          strobe.loadTx = 1'b1;
          if (cmdStart) begin
            stateNext = ST_START;
          end else if (cmdWrite | cmdRead) begin
            stateNext        = ST_DATA;
            strobe.enterData = 1'b1;
            strobe.fromHost  = 1'b1;
          end else if (cmdStop) begin
            stateNext = ST_STOP;
          end else begin
            stateNext = ST_DONE;
          end
        end
      end
      ST_START: begin
        if (finish) begin
          if (wantData) begin
            stateNext        = ST_DATA;
            strobe.enterData = 1'b1;
          end else if (doStop) begin
            stateNext = ST_STOP;
          end else begin
            stateNext = ST_DONE;
          end
        end
      end
      ST_DATA: begin
        if (finish) begin
          strobe.shiftBit = 1'b1;
          if (lastBit) stateNext = ST_ACK;
        end
      end
      ST_ACK: begin
        strobe.copyRx = readMode & ~pending;
        if (finish) begin
          strobe.storeAck = writeMode;
          stateNext       = doStop ? ST_STOP : ST_DONE;
        end
      end
      ST_STOP: begin
        if (finish) stateNext = ST_DONE;
      end
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      pending <= 1'b0;
      doStop  <= 1'b0;
      doRead  <= 1'b0;
      doWrite <= 1'b0;
      ackVal  <= 1'b1;
    end else begin
      state <= stateNext;
      if (bitGo)       pending <= 1'b1;
      else if (finish) pending <= 1'b0;
      if (state == ST_IDLE && cmdValid) begin
        doStop  <= cmdStop;
        doRead  <= cmdRead;
        doWrite <= cmdWrite;
        ackVal  <= ackValue;
      end
    end
  end

  always_comb begin
    bitCmd = BIT_NOP;
    bitTxd = 1'b1;
    unique case (state)
      ST_START: bitCmd = BIT_START;
      ST_STOP:  bitCmd = BIT_STOP;
      ST_DATA: begin
        bitCmd = writeMode ? BIT_WRITE : BIT_READ;
        bitTxd = writeMode ? shiftMsb : 1'b1;
      end
      ST_ACK: begin
        bitCmd = writeMode ? BIT_READ : BIT_WRITE;
        bitTxd = writeMode ? 1'b1 : ackVal;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/i2c_byte_seq.sv
module i2c_byte_seq
  import i2cseq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic              cmdStart,
  input  logic              cmdStop,
  input  logic              cmdRead,
  input  logic              cmdWrite,
  input  logic              ackValue,
  input  logic [DATA_W-1:0] txByte,
  output logic              busy,
  output logic              done,
  output logic              rxAck,
  output logic [DATA_W-1:0] rxByte,
  output logic              bitGo,
  output logic [2:0]        bitCmd,
  output logic              bitTxd,
  input  logic              bitDone,
  input  logic              bitRxd
);

  dpStrobe_t strobe;
  logic shiftMsb;
  logic lastBit;

  i2cseq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdStart (cmdStart),
    .cmdStop  (cmdStop),
    .cmdRead  (cmdRead),
    .cmdWrite (cmdWrite),
    .ackValue (ackValue),
    .shiftMsb (shiftMsb),
    .lastBit  (lastBit),
    .bitDone  (bitDone),
    .strobe   (strobe),
    .bitGo    (bitGo),
    .bitCmd   (bitCmd),
    .bitTxd   (bitTxd),
    .busy     (busy),
    .done     (done)
  );

  i2cseq_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .txByte   (txByte),
    .bitRxd   (bitRxd),
    .shiftMsb (shiftMsb),
    .lastBit  (lastBit),
    .rxAck    (rxAck),
    .rxByte   (rxByte)
  );

endmodule

// File: rtl/i2cseq_checker.sv
module i2cseq_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdValid,
  input logic              busy,
  input logic              done,
  input logic              rxAck,
  input logic [DATA_W-1:0] rxByte,
  input logic              bitGo,
  input logic [2:0]        bitCmd,
  input logic              bitDone
);

  logic outstanding;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        outstanding <= 1'b0;
    else if (bitGo)   outstanding <= 1'b1;
    else if (bitDone) outstanding <= 1'b0;
  end

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rstN)
    bitGo |-> !outstanding); // R3

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9

  AST_DONE_RELEASES_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy); // R9

  AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy); // R9

  AST_IDLE_NO_BITGO: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !bitGo); // R2

  AST_ACCEPT_TO_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !busy) |=> busy); // R2

  AST_BITCMD_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    bitGo |-> (bitCmd >= 3'd1 && bitCmd <= 3'd4)); // R12

  AST_IDLE_HOLDS_RESULTS: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !cmdValid) |=> ($stable(rxAck) && $stable(rxByte))); // R6

endmodule

bind i2c_byte_seq i2cseq_checker #(.DATA_W(DATA_W)) u_checker (
  .clk      (clk),
  .rstN     (rstN),
  .cmdValid (cmdValid),
  .busy     (busy),
  .done     (done),
  .rxAck    (rxAck),
  .rxByte   (rxByte),
  .bitGo    (bitGo),
  .bitCmd   (bitCmd),
  .bitDone  (bitDone)
);

// File: tb/i2c_byte_seq_bench.sv
module i2c_byte_seq_bench;

  localparam int LAT = 1;           // bit engine answer latency
  localparam int PER = LAT + 2;     // cycles per bit command

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0, cmdStart = 1'b0, cmdStop = 1'b0;
  logic cmdRead = 1'b0, cmdWrite = 1'b0, ackValue = 1'b0;
  logic [7:0] txByte = 8'h00;
  logic busy, done, rxAck, bitGo, bitTxd;
  logic [7:0] rxByte;
  logic [2:0] bitCmd;
  logic bitDone = 1'b0, bitRxd = 1'b0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  i2c_byte_seq u_i2c_byte_seq (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdStart(cmdStart),
    .cmdStop(cmdStop), .cmdRead(cmdRead), .cmdWrite(cmdWrite),
    .ackValue(ackValue), .txByte(txByte), .busy(busy), .done(done),
    .rxAck(rxAck), .rxByte(rxByte), .bitGo(bitGo), .bitCmd(bitCmd),
    .bitTxd(bitTxd), .bitDone(bitDone), .bitRxd(bitRxd)
  );

  // Bit engine model with command log
  logic       clrLog = 1'b0;
  logic [2:0] logCmd [0:31];
  logic       logTxd [0:31];
  int         logN = 0;
  int         rdN = 0;
  logic       respBits [0:15];
  int         latCnt = 0;
  logic       nextRx = 1'b0;

  always @(posedge clk) begin
    bitDone <= 1'b0;
    if (clrLog) begin
      logN <= 0;
      rdN  <= 0;
    end else if (bitGo) begin
      if (logN < 32) begin
        logCmd[logN] <= bitCmd;
        logTxd[logN] <= bitTxd;
      end
      logN   <= logN + 1;
      latCnt <= LAT;
      if (bitCmd == 3'd4) begin
        nextRx <= respBits[rdN];
        rdN    <= rdN + 1;
      end
    end else if (latCnt != 0) begin
      latCnt <= latCnt - 1;
      if (latCnt == 1) begin
        bitDone <= 1'b1;
        bitRxd  <= nextRx;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic runTxn(input bit s, input bit p, input bit rd, input bit wr,
                        input bit ackv, input logic [7:0] tx,
                        input logic [7:0] rdByte, input bit slvAck,
                        input bit intrude);
    logic [2:0] eCmd [0:15];
    logic       eTxd [0:15];
    bit         eCare [0:15];
    int n = 0;
    int cyc = 0;
    int badOrder = 0;
    int badData = 0;
    logic prevAck;
    logic [7:0] prevByte;
    if (wr) respBits[0] = slvAck;
    else for (int i = 0; i < 8; i++) respBits[i] = rdByte[7-i];
    if (s) begin eCmd[n] = 3'd1; eTxd[n] = 1'b1; eCare[n] = 1'b0; n++; end
    if (wr || rd) begin
      for (int i = 0; i < 8; i++) begin
        eCmd[n] = wr ? 3'd3 : 3'd4;
        eTxd[n] = wr ? tx[7-i] : 1'b1;
        eCare[n] = 1'b1;
        n++;
      end
      eCmd[n] = wr ? 3'd4 : 3'd3;
      eTxd[n] = ackv;
      eCare[n] = !wr;
      n++;
    end
    if (p) begin eCmd[n] = 3'd2; eTxd[n] = 1'b1; eCare[n] = 1'b0; n++; end

    @(negedge clk);
    clrLog = 1'b1;
    @(negedge clk);
    clrLog = 1'b0;
    prevAck = rxAck;
    prevByte = rxByte;
    cmdValid = 1'b1; cmdStart = s; cmdStop = p; cmdRead = rd;
    cmdWrite = wr; ackValue = ackv; txByte = tx;
    @(negedge clk);
    cmdValid = 1'b0;
    while (!done && cyc < 1000) begin
      @(negedge clk);
      cyc++;
      if (intrude && cyc == 4) begin
        cmdValid = 1'b1; cmdStart = 1'b1; cmdStop = 1'b1;
        cmdRead = 1'b1; cmdWrite = 1'b0; txByte = ~tx; ackValue = ~ackv;
      end else if (intrude && cyc == 5) begin
        cmdValid = 1'b0;
      end
    end
    chk(cyc == n * PER, "R9", "done latency", cyc, n * PER);
    chk(logN == n, "R4", "bit command count", logN, n);
    for (int i = 0; i < n && i < logN; i++) begin
      if (logCmd[i] != eCmd[i]) badOrder++;
      if (eCare[i] && logTxd[i] != eTxd[i]) badData++;
    end
    chk(badOrder == 0, "R4 R12", "command order mismatches", badOrder, 0);
    if (wr) chk(badData == 0, "R5", "transmit bit mismatches", badData, 0);
    else if (rd) chk(badData == 0, "R8 R12", "receive/ack bit mismatches", badData, 0);
    if (wr) begin
      chk(rxAck == slvAck, "R6", "rxAck", rxAck, slvAck);
      chk(rxByte == prevByte, "R6", "rxByte kept", rxByte, prevByte);
    end else if (rd) begin
      chk(rxByte == rdByte, "R7", "rxByte", rxByte, rdByte);
      chk(rxAck == prevAck, "R7", "rxAck kept", rxAck, prevAck);
    end else begin
      chk(rxByte == prevByte && rxAck == prevAck, "R11", "results kept",
          {rxAck, rxByte}, {prevAck, prevByte});
    end
    @(negedge clk);
    chk(!done && !busy, "R9", "done/busy after pulse", {done, busy}, 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !bitGo, "R1", "busy/done/bitGo after reset",
        {busy, done, bitGo}, 0);
    chk(rxByte == 8'h00 && rxAck == 1'b1, "R1", "rxByte/rxAck after reset",
        {rxAck, rxByte}, 9'h100);
    rstN = 1'b1;
    @(negedge clk);

    // R5 R6: every transmit byte, varied start/stop and slave ack
    for (int v = 0; v < 256; v++)
      runTxn(v[0], v[1], 1'b0, 1'b1, 1'b0, 8'(v), 8'h00, v[2] ^ v[5], 1'b0);

    // R7 R8: every receive byte, varied acknowledge value
    for (int v = 0; v < 256; v++)
      runTxn(v[1], v[2], 1'b1, 1'b0, v[0], 8'h00, 8'(v ^ 8'h3C), 1'b0, 1'b0);

    // Address byte: 7-bit address 0x52, read direction, with start
    runTxn(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, {7'h52, 1'b1}, 8'h00, 1'b0, 1'b0);

    // R10: both read and write set -> transmit
    runTxn(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'hA6, 8'h00, 1'b1, 1'b0);
    runTxn(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h19, 8'h00, 1'b0, 1'b0);

    // R11: no flags
    runTxn(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 8'h00, 1'b0, 1'b0);

    // R4: start only, stop only, start+stop
    runTxn(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0);
    runTxn(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0);
    runTxn(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0);

    // R2: request arriving while busy is ignored
    runTxn(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'hC3, 8'h00, 1'b0, 1'b1);
    runTxn(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 8'h81, 1'b0, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule